// File: doc/BRIEF.md
# Aperture Page Remapping Translator

This block turns bus addresses that land inside a programmable remapping window into wider physical addresses. The window is a power-of-two region whose base and size come from configuration registers; every 4 KiB page inside it is described by one 32-bit entry in an internal page table. An entry carries a valid flag and the physical page number, split so that physical bits 31:12 sit in entry bits 31:12 and physical bits 39:32 sit in entry bits 11:4. Addresses outside the window, and every address while translation is disabled, pass through with zero upper bits.

Software loads the table through a dedicated write port and programs the window through a small register port. A direct-mapped cache of recently used entries sits in front of the table. Table writes do not touch the cache, so software must issue a flush after changing entries. The flush register reports busy while the cache is being cleared, one line per cycle, and new requests are held off during that time. A request inside the window whose entry is invalid, or whose page index lies beyond the table, raises the fault flag and returns address zero.

Top module: `aperture_xlate`

## Requirements
- R1: After reset the control, window base and table base registers read 0, the flush busy bit reads 0, reqReady is 1, respValid is 0 and no cache line is valid.
- R2: Register select 0 is control (bit 0 enable, bits 3:1 size order, all higher bits including 4 and 5 read 0), select 1 is the window base (bits 14:0 kept, higher bits read 0), select 2 is the table base (bits 31:4 kept, bits 3:0 read 0), select 3 is flush (bit 0 busy, other bits read 0).
- R3: With control bit 0 clear, every accepted request returns respAddr = {8'h00, reqAddr} with respFault 0.
- R4: The window starts at (base field << 25) and spans 32 MiB << order; an address at or above the start and below start plus span is translated, any other address passes through as in R3.
- R5: The window is absent, and all addresses pass through, when the base field is 0 or when start plus span is at least 0xFFFFFFFF.
- R6: A translated address uses entry index (addr - start) >> 12 and returns {entry[11:4], entry[31:12], addr[11:0]} with respFault 0 when entry bit 0 is 1.
- R7: A translated address whose entry has bit 0 clear, or whose index is at least the table depth, returns respAddr 0 with respFault 1.
- R8: An entry fetched from the table is kept in cache line (index mod line count); a later table write to that index is not seen while the line still holds it, and is seen after the line is replaced by another index or after a flush.
- R9: Writing the flush register with bit 0 set makes its bit 0 read 1 for exactly as many cycles as there are cache lines, then 0; writing it with bit 0 clear has no effect.
- R10: While a flush is busy reqReady is 0 and a raised reqValid produces no response.
- R11: A request accepted at a clock edge (reqValid and reqReady high) gives respValid high for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Register write strobe |
| cfgSel | input | 2 | Register select |
| cfgWdata | input | 32 | Register write data |
| cfgRdata | output | 32 | Register read data for cfgSel |
| tblWe | input | 1 | Page table write strobe |
| tblIdx | input | TI_W | Page table write index |
| tblData | input | 32 | Page table entry to write |
| reqValid | input | 1 | Translation request |
| reqAddr | input | 32 | Bus address to translate |
| reqReady | output | 1 | Request can be accepted |
| respValid | output | 1 | Response valid |
| respAddr | output | 40 | Physical address |
| respFault | output | 1 | Invalid or out-of-table entry hit |

## Verification
The bench sweeps every table index with varied offsets and entry patterns, so a design that swapped the two physical fields or dropped the page offset returns wrong addresses. It probes the first and last byte of the window and the bytes just outside it, where an off-by-one in the range compare either translates a passthrough address or passes a windowed one, and it picks bases whose end lands exactly on the absence limit, which a design using the wrong comparison would still translate. It rewrites cached entries to show a cache that snoops table writes, or a flush that skips lines, returning the new value too early or a stale one too late, and it times the busy bit and stalls requests during a flush to catch a flush of the wrong length or one that lets requests through.

// File: rtl/apx_pkg.sv
package apx_pkg;
  localparam int PAGE_SHIFT = 12;
  localparam int WIN_SHIFT  = 25;
  localparam int PHYS_W     = 40;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_BASE  = 2'd1,
    SEL_TBASE = 2'd2,
    SEL_FLUSH = 2'd3
  } cfgSel_e;

  typedef struct packed {
    logic accept;    // request taken this cycle
    logic flushClr;  // clear the cache line named by flushIdx
  } ctlStrobe_t;
endpackage

// File: rtl/apx_ctrl.sv
module apx_ctrl
  import apx_pkg::*;
#(
  parameter int CACHE_LINES = 4,
  localparam int CL_W = $clog2(CACHE_LINES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [1:0]       cfgSel,
  input  logic [31:0]      cfgWdata,
  output logic [31:0]      cfgRdata,
  input  logic             reqValid,
  output logic             reqReady,
  output ctlStrobe_t       strobe,
  output logic [CL_W-1:0]  flushIdx,
  output logic             flushBusy,
  output logic             xlateEn,
  output logic [2:0]       sizeOrder,
  output logic [14:0]      baseField
);
  localparam logic [CL_W-1:0] LAST_LINE = CL_W'(CACHE_LINES - 1);

  logic [3:0]  ctrlReg;
  logic [14:0] baseReg;
  logic [27:0] tbaseReg;
  logic [CL_W-1:0] flushCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg   <= '0;
      baseReg   <= '0;
      tbaseReg  <= '0;
      flushBusy <= 1'b0;
      flushCnt  <= '0;
    end else begin
      if (cfgWe) begin
        unique case (cfgSel_e'(cfgSel))
          SEL_CTRL:  ctrlReg  <= cfgWdata[3:0];
          SEL_BASE:  baseReg  <= cfgWdata[14:0];
          SEL_TBASE: tbaseReg <= cfgWdata[31:4];
          SEL_FLUSH: if (cfgWdata[0] && !flushBusy) begin
            flushBusy <= 1'b1;
            flushCnt  <= '0;
          end
          default: ;
        endcase
      end
      if (flushBusy) begin
        flushCnt <= flushCnt + 1'b1;
        if (flushCnt == LAST_LINE) flushBusy <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (cfgSel_e'(cfgSel))
      SEL_CTRL:  cfgRdata = {28'd0, ctrlReg};
      SEL_BASE:  cfgRdata = {17'd0, baseReg};
      SEL_TBASE: cfgRdata = {tbaseReg, 4'd0};
      SEL_FLUSH: cfgRdata = {31'd0, flushBusy};
      default:   cfgRdata = '0;
    endcase
  end

  assign reqReady        = !flushBusy;
  assign strobe.accept   = reqValid && !flushBusy;
  assign strobe.flushClr = flushBusy;
  assign flushIdx        = flushCnt;
  assign xlateEn         = ctrlReg[0];
  assign sizeOrder       = ctrlReg[3:1];
  assign baseField       = baseReg;
endmodule

// File: rtl/apx_datapath.sv
module apx_datapath
  import apx_pkg::*;
#(
  parameter int TABLE_DEPTH = 64,
  parameter int CACHE_LINES = 4,
  localparam int TI_W = $clog2(TABLE_DEPTH),
  localparam int CL_W = $clog2(CACHE_LINES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [CL_W-1:0]   flushIdx,
  input  logic              xlateEn,
  input  logic [2:0]        sizeOrder,
  input  logic [14:0]       baseField,
  input  logic [31:0]       reqAddr,
  input  logic              tblWe,
  input  logic [TI_W-1:0]   tblIdx,
  input  logic [31:0]       tblData,
  output logic              respValid,
  output logic [PHYS_W-1:0] respAddr,
  output logic              respFault
);
  localparam logic [19:0] DEPTH_L   = 20'(TABLE_DEPTH);
  localparam logic [40:0] MIN_SPAN  = 41'(1) << WIN_SHIFT;
  localparam logic [40:0] END_LIMIT = 41'h0_FFFF_FFFF;

  logic [31:0] pageTbl [TABLE_DEPTH];
  logic        lineValid [CACHE_LINES];
  logic [19:0] lineTag   [CACHE_LINES];
  logic [31:0] lineData  [CACHE_LINES];

  // window decode
  logic [40:0] winStart, winSpan, winEnd, addrWide;
  logic        winPresent, inWin;
  logic [31:0] winOffs;
  logic [19:0] pageIdx;
  logic [CL_W-1:0] lineSel;
  logic        inTable, lineHit;
  logic [31:0] entry;

  always_comb begin
    winStart   = {1'b0, baseField, 25'd0};
    winSpan    = MIN_SPAN << sizeOrder;
    winEnd     = winStart + winSpan;
    winPresent = (baseField != '0) && (winEnd < END_LIMIT);
    addrWide   = {9'd0, reqAddr};
    inWin      = xlateEn && winPresent && (addrWide >= winStart) && (addrWide < winEnd);
    winOffs    = reqAddr - winStart[31:0];
    pageIdx    = winOffs[31:PAGE_SHIFT];
    lineSel    = pageIdx[CL_W-1:0];
    inTable    = pageIdx < DEPTH_L;
    lineHit    = lineValid[lineSel] && (lineTag[lineSel] == pageIdx);
    entry      = lineHit ? lineData[lineSel] : pageTbl[pageIdx[TI_W-1:0]];
  end

  // page table storage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < TABLE_DEPTH; i++) pageTbl[i] <= '0;
    end else if (tblWe) begin
      pageTbl[tblIdx] <= tblData;
    end
  end

  // entry cache, one generate slice per line
  for (genvar g = 0; g < CACHE_LINES; g++) begin : gLine
    logic fillHere;
    assign fillHere = strobe.accept && inWin && inTable && !lineHit &&
                      (lineSel == CL_W'(g));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        lineValid[g] <= 1'b0;
        lineTag[g]   <= '0;
        lineData[g]  <= '0;
      end else if (strobe.flushClr && flushIdx == CL_W'(g)) begin
        lineValid[g] <= 1'b0;
      end else if (fillHere) begin
        lineValid[g] <= 1'b1;
        lineTag[g]   <= pageIdx;
        lineData[g]  <= entry;
      end
    end
  end

  // response register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respAddr  <= '0;
      respFault <= 1'b0;
    end else begin
      respValid <= strobe.accept;
      if (strobe.accept) begin
        if (!inWin) begin
          respAddr  <= {8'd0, reqAddr};
          respFault <= 1'b0;
        end else if (!inTable || !entry[0]) begin
          respAddr  <= '0;
          respFault <= 1'b1;
        end else begin
          respAddr  <= {entry[11:4], entry[31:12], reqAddr[11:0]};
          respFault <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/aperture_xlate.sv
module aperture_xlate
  import apx_pkg::*;
#(
  parameter int TABLE_DEPTH = 64,
  parameter int CACHE_LINES = 4,
  localparam int TI_W = $clog2(TABLE_DEPTH),
  localparam int CL_W = $clog2(CACHE_LINES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [31:0]       cfgWdata,
  output logic [31:0]       cfgRdata,
  input  logic              tblWe,
  input  logic [TI_W-1:0]   tblIdx,
  input  logic [31:0]       tblData,
  input  logic              reqValid,
  input  logic [31:0]       reqAddr,
  output logic              reqReady,
  output logic              respValid,
  output logic [PHYS_W-1:0] respAddr,
  output logic              respFault
);
  ctlStrobe_t      strobe;
  logic [CL_W-1:0] flushIdx;
  logic            flushBusy, xlateEn;
  logic [2:0]      sizeOrder;
  logic [14:0]     baseField;

  apx_ctrl #(.CACHE_LINES(CACHE_LINES)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .reqValid(reqValid),
    .reqReady(reqReady), .strobe(strobe), .flushIdx(flushIdx),
    .flushBusy(flushBusy), .xlateEn(xlateEn), .sizeOrder(sizeOrder),
    .baseField(baseField)
  );

  apx_datapath #(.TABLE_DEPTH(TABLE_DEPTH), .CACHE_LINES(CACHE_LINES)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .flushIdx(flushIdx),
    .xlateEn(xlateEn), .sizeOrder(sizeOrder), .baseField(baseField),
    .reqAddr(reqAddr), .tblWe(tblWe), .tblIdx(tblIdx), .tblData(tblData),
    .respValid(respValid), .respAddr(respAddr), .respFault(respFault)
  );
endmodule

// File: rtl/apx_checker.sv
module apx_checker #(
  parameter int CACHE_LINES = 4
) (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic [31:0] reqAddr,
  input logic        reqReady,
  input logic        respValid,
  input logic [39:0] respAddr,
  input logic        respFault,
  input logic        xlateEn,
  input logic        flushBusy
);
  int busyRun;
  always_ff @(posedge clk) begin
    if (!rstN) busyRun <= 0;
    else if (flushBusy) busyRun <= busyRun + 1;
    else busyRun <= 0;
  end

  // R11
  resp_follows_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> respValid);

  // R10
  no_resp_when_stalled_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=> !respValid);

  // R7
  fault_zero_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respFault) |-> (respAddr == '0));

  // R3
  disabled_passthru_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !xlateEn) |=> (respAddr == {8'd0, $past(reqAddr)} && !respFault));

  // R9
  flush_length_chk: assert property (@(posedge clk) disable iff (!rstN)
    busyRun <= CACHE_LINES);

  // R10
  ready_tracks_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushBusy |-> !reqReady);
endmodule

bind aperture_xlate apx_checker #(.CACHE_LINES(CACHE_LINES)) uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
  .reqReady(reqReady), .respValid(respValid), .respAddr(respAddr),
  .respFault(respFault), .xlateEn(xlateEn), .flushBusy(flushBusy)
);

// File: tb/aperture_xlate_test.sv
module aperture_xlate_test;
  localparam int DEPTH = 16;
  localparam int LINES = 4;
  localparam int TI_W  = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [1:0] cfgSel = '0;
  logic [31:0] cfgWdata = '0;
  logic [31:0] cfgRdata;
  logic tblWe = 1'b0;
  logic [TI_W-1:0] tblIdx = '0;
  logic [31:0] tblData = '0;
  logic reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic reqReady, respValid, respFault;
  logic [39:0] respAddr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  aperture_xlate #(.TABLE_DEPTH(DEPTH), .CACHE_LINES(LINES)) uut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .tblWe(tblWe),
    .tblIdx(tblIdx), .tblData(tblData), .reqValid(reqValid),
    .reqAddr(reqAddr), .reqReady(reqReady), .respValid(respValid),
    .respAddr(respAddr), .respFault(respFault)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = sel; cfgWdata = data;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic cfgRead(input logic [1:0] sel, output logic [31:0] data);
    cfgSel = sel;
    #1 data = cfgRdata;
  endtask

  task automatic tblWrite(input int idx, input logic [31:0] data);
    @(negedge clk);
    tblWe = 1'b1; tblIdx = TI_W'(idx); tblData = data;
    @(negedge clk);
    tblWe = 1'b0;
  endtask

  // one request; result sampled on the negedge after acceptance
  task automatic xlate(input logic [31:0] a, output logic [39:0] pa, output logic flt, output logic vld);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a;
    @(negedge clk);
    reqValid = 1'b0;
    pa = respAddr; flt = respFault; vld = respValid;
  endtask

  function automatic logic [31:0] entryOf(input int i, input int gen);
    logic [19:0] lo;
    logic [7:0]  hi;
    lo = 20'((i * 32'h1357 + 32'hA0000 + gen * 32'h777) & 32'hFFFFF);
    hi = 8'(i * 17 + 3 + gen * 5);
    return {lo, hi, 2'b00, 1'b1, (i != 5) ? 1'b1 : 1'b0};
  endfunction

  function automatic logic [39:0] physOf(input logic [31:0] e, input logic [31:0] a);
    return {e[11:4], e[31:12], a[11:0]};
  endfunction

  task automatic expectXlate(input string req, input logic [31:0] a,
                             input logic [39:0] expA, input logic expF);
    logic [39:0] pa; logic flt, vld;
    xlate(a, pa, flt, vld);
    check(req, {63'd0, vld}, 64'd1);
    check(req, {24'd0, pa}, {24'd0, expA});
    check(req, {63'd0, flt}, {63'd0, expF});
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] a;
    logic [39:0] pa;
    logic flt, vld;
    int busyCycles;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int s = 0; s < 4; s++) begin
      cfgRead(2'(s), rd);
      check("R1 reg reset", {32'd0, rd}, 64'd0);
    end
    check("R1 ready", {63'd0, reqReady}, 64'd1);
    check("R1 respValid", {63'd0, respValid}, 64'd0);

    // R2 readback masks
    cfgWrite(2'd0, 32'hFFFF_FFF0 | 32'h0000_000E);
    cfgRead(2'd0, rd);
    check("R2 ctrl mask, bits 4 and 5 zero", {32'd0, rd}, 64'h0000_000E);
    cfgWrite(2'd1, 32'hFFFF_ABCD);
    cfgRead(2'd1, rd);
    check("R2 base mask", {32'd0, rd}, 64'h0000_2BCD);
    cfgWrite(2'd2, 32'h1234_567F);
    cfgRead(2'd2, rd);
    check("R2 table base mask", {32'd0, rd}, 64'h1234_5670);

    // load table
    for (int i = 0; i < DEPTH; i++) tblWrite(i, entryOf(i, 0));

    // R3 disabled: base 1, order 0, enable off
    cfgWrite(2'd1, 32'd1);
    cfgWrite(2'd0, 32'd0);
    for (int k = 0; k < 8; k++) begin
      a = 32'h0200_0000 + 32'(k) * 32'h0000_1111;
      expectXlate("R3 disabled passthru", a, {8'd0, a}, 1'b0);
    end

    // enable, order 0: window 0x02000000..0x03FFFFFF
    cfgWrite(2'd0, 32'd1);
    // R6 / R7 sweep over every table index
    for (int i = 0; i < DEPTH; i++) begin
      a = 32'h0200_0000 + 32'(i) * 32'h1000 + ((32'(i) * 32'h155) & 32'hFFF);
      if (i == 5) expectXlate("R7 invalid entry", a, 40'd0, 1'b1);
      else        expectXlate("R6 translate", a, physOf(entryOf(i, 0), a), 1'b0);
    end
    // R7 index beyond table
    expectXlate("R7 beyond table", 32'h0200_0000 + 32'(DEPTH) * 32'h1000 + 32'h10, 40'd0, 1'b1);
    // R4 window edges
    expectXlate("R4 below start", 32'h01FF_FFFF, 40'h00_01FF_FFFF, 1'b0);
    expectXlate("R4 at end", 32'h0400_0000, 40'h00_0400_0000, 1'b0);
    expectXlate("R4 last byte inside", 32'h03FF_FFFF, 40'd0, 1'b1);
    // R4 order 2 widens window to 128 MiB
    cfgWrite(2'd0, 32'h5);
    expectXlate("R4 order2 inside", 32'h09FF_F000, 40'd0, 1'b1);
    expectXlate("R4 order2 at end", 32'h0A00_0000, 40'h00_0A00_0000, 1'b0);
    expectXlate("R4 order2 first page", 32'h0200_0ABC, physOf(entryOf(0, 0), 32'h0200_0ABC), 1'b0);

    // R5 absence rules
    cfgWrite(2'd0, 32'h1);
    cfgWrite(2'd1, 32'h7E);  // 0xFC000000 + 32 MiB = 0xFE000000 present
    expectXlate("R5 high window present", 32'hFC00_1234, physOf(entryOf(1, 0), 32'hFC00_1234), 1'b0);
    cfgWrite(2'd1, 32'h7F);  // end 0x100000000 -> absent
    expectXlate("R5 end past limit", 32'hFE00_1234, 40'h00_FE00_1234, 1'b0);
    cfgWrite(2'd1, 32'h7E);
    cfgWrite(2'd0, 32'h3);   // order 1: end 0x100000000 -> absent
    expectXlate("R5 order makes absent", 32'hFC00_1234, 40'h00_FC00_1234, 1'b0);
    cfgWrite(2'd0, 32'h1);
    cfgWrite(2'd1, 32'h0);
    expectXlate("R5 zero base", 32'h0000_1234, 40'h00_0000_1234, 1'b0);
    cfgWrite(2'd1, 32'h4001);
    expectXlate("R5 base above 4G", 32'h0200_1234, 40'h00_0200_1234, 1'b0);

    // R8 stale cache behaviour (window back at base 1)
    cfgWrite(2'd1, 32'h1);
    a = 32'h0200_F040;  // index 15, line 3
    expectXlate("R8 prime line", a, physOf(entryOf(15, 0), a), 1'b0);
    tblWrite(15, entryOf(15, 1));
    expectXlate("R8 stale after table write", a, physOf(entryOf(15, 0), a), 1'b0);
    expectXlate("R8 evict with index 11", 32'h0200_B000, physOf(entryOf(11, 0), 32'h0200_B000), 1'b0);
    expectXlate("R8 new value after eviction", a, physOf(entryOf(15, 1), a), 1'b0);
    a = 32'h0200_E7F0;  // index 14
    expectXlate("R8 prime index 14", a, physOf(entryOf(14, 0), a), 1'b0);
    tblWrite(14, entryOf(14, 2));

    // R9 flush with bit 0 clear does nothing
    cfgWrite(2'd3, 32'hFFFF_FFFE);
    cfgRead(2'd3, rd);
    check("R9 no flush on bit0 clear", {32'd0, rd}, 64'd0);
    expectXlate("R9 still stale", a, physOf(entryOf(14, 0), a), 1'b0);

    // R9 / R10 flush timing and stall
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = 2'd3; cfgWdata = 32'h1;
    @(negedge clk);
    cfgWe = 1'b0;
    busyCycles = 0;
    // first busy cycle: try a request
    check("R10 ready low", {63'd0, reqReady}, 64'd0);
    reqValid = 1'b1; reqAddr = a;
    for (int c = 0; c < 20; c++) begin
      cfgRead(2'd3, rd);
      if (rd[0]) busyCycles++;
      @(negedge clk);
      if (c == 0) begin
        reqValid = 1'b0;
        check("R10 no response while busy", {63'd0, respValid}, 64'd0);
      end
    end
    check("R9 busy length", 64'(busyCycles), 64'(LINES));
    cfgRead(2'd3, rd);
    check("R9 busy cleared", {32'd0, rd}, 64'd0);
    expectXlate("R8 new value after flush", a, physOf(entryOf(14, 2), a), 1'b0);

    // R11 back-to-back requests each answered one cycle later
    @(negedge clk);
    reqValid = 1'b1; reqAddr = 32'h0200_2000;
    @(negedge clk);
    check("R11 first resp", {63'd0, respValid}, 64'd1);
    check("R11 first addr", {24'd0, respAddr}, {24'd0, physOf(entryOf(2, 0), 32'h0200_2000)});
    reqAddr = 32'h0200_3008;
    @(negedge clk);
    reqValid = 1'b0;
    check("R11 second addr", {24'd0, respAddr}, {24'd0, physOf(entryOf(3, 0), 32'h0200_3008)});
    @(negedge clk);
    check("R11 resp drops", {63'd0, respValid}, 64'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule